// File: doc/BRIEF.md
# Configuration Port Controller with Key-Gated Access

This block implements a legacy two-port configuration interface on an 8-bit I/O bus. An index port at a parameterised base address chooses the register to reach. The data port at the next address is the window through which that register is read or written. All access is locked after reset. A host opens configuration mode by writing an opening key twice in a row to the index port, and closes it again by writing a closing key to the same port.

While open, the block answers a small set of global registers by itself: a logical-device number register, a two-byte device identifier, a revision byte and a two-byte vendor identifier. Register numbers from 0x30 upward belong to the currently selected logical device. The block forwards those accesses over a simple register-bus port: register number, device number, write data, read data, and one-cycle read and write strobes. The logical devices themselves sit outside this block.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the interface is locked, the index register holds 0x00 and the logical-device number (ld_num) is 0x00. io_rdata resets to 0xFF.
- R2: Configuration mode opens only after two consecutive writes of 0x87 to the index port (address BASE_ADDR).
- R3: While the first key is pending, any index-port write other than 0x87 returns the sequence to its start, so two further 0x87 writes are then needed.
- R4: In configuration mode, a write of 0xAA to the index port locks the interface. The index register is not changed by that write and keeps its value across the locked period.
- R5: While locked (including after a single key), index-port writes do not load the index, data-port writes are ignored, reads of either port return 0xFF, and ld_wr and ld_rd stay low.
- R6: In configuration mode, an index-port write of any value other than 0xAA loads the index register, and an index-port read returns it. Read data appears on io_rdata in the cycle after io_rd and holds until the next read of a port.
- R7: Index 0x07 is the read/write logical-device number register; its value drives ld_num.
- R8: Indices 0x20/0x21 read the device ID high/low byte, 0x22 the revision, and 0x23/0x24 the vendor ID (default 0x1934) high/low byte. These are read-only. Other indices below 0x30 read 0x00 and ignore writes.
- R9: A data-port write at an index of 0x30 or above gives a one-cycle ld_wr pulse in the next cycle, with ld_reg equal to the index and ld_wdata equal to the data. A read at such an index returns the ld_rdata present during the io_rd cycle and gives a one-cycle ld_rd pulse in the next cycle.
- R10: Accesses to addresses other than BASE_ADDR and BASE_ADDR+1 have no effect on any state or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |
| ld_num | output | 8 | Currently selected logical-device number |
| ld_reg | output | 8 | Register number presented to the logical device |
| ld_wdata | output | 8 | Write data for the logical device |
| ld_wr | output | 1 | One-cycle write strobe to the logical device |
| ld_rd | output | 1 | One-cycle read strobe to the logical device |
| ld_rdata | input | 8 | Read data from the selected logical device |

## Verification
The hardest state to reach from the ports is a half-open sequencer that is disturbed partway. This is a first key followed by a different index value, a second key and then data accesses. The bench reaches it by writing the keys one at a time and probing the data port in between; a read of 0xFF proves the block has not opened early. The closing key's effect on the index register is seen only after a later unlock. For that reason the bench selects an index, locks the interface, attempts writes while locked, reopens it and reads the index port back.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_t;

  localparam logic [7:0] IDX_LDSEL  = 8'h07;
  localparam logic [7:0] IDX_DEV_HI = 8'h20;
  localparam logic [7:0] IDX_DEV_LO = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_VEN_HI = 8'h23;
  localparam logic [7:0] IDX_VEN_LO = 8'h24;
  localparam logic [7:0] IDX_FWD_LO = 8'h30;
  localparam logic [7:0] LOCKED_RD  = 8'hFF;
endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
#(
  parameter logic [7:0] KEY_OPEN  = 8'h87,
  parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);
  lock_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        LK_CLOSED: if (wdata == KEY_OPEN) st_d = LK_HALF;
        LK_HALF:   st_d = (wdata == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   if (wdata == KEY_CLOSE) st_d = LK_CLOSED;
        default:   st_d = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LK_CLOSED;
    else     st_q <= st_d;
  end

  assign cfg_open = (st_q == LK_OPEN);
  assign idx_load = cfg_open && idx_wr && (wdata != KEY_CLOSE);

  AST_OPEN_TWO_KEYS: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(st_q == LK_HALF && idx_wr && wdata == KEY_OPEN)); // R2
  AST_BAD_KEY_RESTART: assert property (@(posedge clk) disable iff (rst)
    (st_q == LK_HALF && idx_wr && wdata != KEY_OPEN) |=> (st_q == LK_CLOSED)); // R3
  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && idx_wr && wdata == KEY_CLOSE) |=> !cfg_open); // R4
endmodule

// File: rtl/cfgp_globals.sv
module cfgp_globals
  import cfgp_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'h0541,
  parameter logic [7:0]  REV    = 8'h12,
  parameter logic [15:0] VEN_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst)                             ldn <= 8'h00;
    else if (wr_en && idx == IDX_LDSEL)  ldn <= wdata;
  end

  always_comb begin
    unique case (idx)
      IDX_LDSEL:  rd_val = ldn;
      IDX_DEV_HI: rd_val = DEV_ID[15:8];
      IDX_DEV_LO: rd_val = DEV_ID[7:0];
      IDX_REV:    rd_val = REV;
      IDX_VEN_HI: rd_val = VEN_ID[15:8];
      IDX_VEN_LO: rd_val = VEN_ID[7:0];
      default:    rd_val = 8'h00;
    endcase
  end

  AST_LDN_ONLY_SELECT: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == IDX_LDSEL) |=> $stable(ldn)); // R7
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter logic [15:0] DEV_ID    = 16'h0541,
  parameter logic [7:0]  REV       = 8'h12,
  parameter logic [15:0] VEN_ID    = 16'h1934,
  parameter logic [7:0]  KEY_OPEN  = 8'h87,
  parameter logic [7:0]  KEY_CLOSE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [7:0]        ld_num,
  output logic [7:0]        ld_reg,
  output logic [7:0]        ld_wdata,
  output logic              ld_wr,
  output logic              ld_rd,
  input  logic [7:0]        ld_rdata
);
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_ADDR + 16'd1);

  logic       idx_hit, dat_hit, cfg_open, idx_load, fwd_sel, dat_wr_ok;
  logic [7:0] index_q, glb_val;

  assign idx_hit   = (io_addr == IDX_PORT);
  assign dat_hit   = (io_addr == DAT_PORT);
  assign fwd_sel   = (index_q >= IDX_FWD_LO);
  assign dat_wr_ok = io_wr && dat_hit && cfg_open;

  cfgp_unlock #(.KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_unlock (
    .clk(clk), .rst(rst), .idx_wr(io_wr && idx_hit), .wdata(io_wdata),
    .cfg_open(cfg_open), .idx_load(idx_load)
  );

  cfgp_globals #(.DEV_ID(DEV_ID), .REV(REV), .VEN_ID(VEN_ID)) u_globals (
    .clk(clk), .rst(rst), .wr_en(dat_wr_ok && !fwd_sel), .idx(index_q),
    .wdata(io_wdata), .ldn(ld_num), .rd_val(glb_val)
  );

  always_ff @(posedge clk) begin
    if (rst)           index_q <= 8'h00;
    else if (idx_load) index_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_wr    <= 1'b0;
      ld_rd    <= 1'b0;
      ld_wdata <= 8'h00;
    end else begin
      ld_wr <= dat_wr_ok && fwd_sel;
      ld_rd <= io_rd && dat_hit && cfg_open && fwd_sel;
      if (dat_wr_ok && fwd_sel) ld_wdata <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= LOCKED_RD;
    else if (io_rd && idx_hit)
      io_rdata <= cfg_open ? index_q : LOCKED_RD;
    else if (io_rd && dat_hit)
      io_rdata <= !cfg_open ? LOCKED_RD : (fwd_sel ? ld_rdata : glb_val);
  end

  assign ld_reg = index_q;

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (io_rd && (idx_hit || dat_hit) && !cfg_open) |=> (io_rdata == 8'hFF)); // R5
  AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> (!ld_wr && !ld_rd)); // R5
  AST_INDEX_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(ld_reg)); // R4
  AST_FWD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ld_wr || ld_rd) |-> (ld_reg >= 8'h30)); // R9
  AST_FOREIGN_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!idx_hit && !dat_hit) |=> ($stable(io_rdata) && !ld_wr && !ld_rd)); // R10
endmodule

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;
  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata, ld_num, ld_reg, ld_wdata, ld_rdata;
  logic        ld_wr, ld_rd;
  int          n_chk = 0, n_fail = 0, wr_pulses = 0, rd_pulses = 0;

  always #5 clk = ~clk;

  assign ld_rdata = ld_reg ^ ld_num ^ 8'h5A;

  cfg_port_ctrl u_cfg_port_ctrl (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_num(ld_num), .ld_reg(ld_reg),
    .ld_wdata(ld_wdata), .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_rdata(ld_rdata)
  );

  always @(negedge clk) begin
    if (ld_wr) wr_pulses++;
    if (ld_rd) rd_pulses++;
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rdata reset", io_rdata, 8'hFF);
    check("R1 ld_num reset", ld_num, 8'h00);
    check("R1 ld_reg reset", ld_reg, 8'h00);
    io_read(IP, v);  check("R5 locked index read", v, 8'hFF);
    io_write(IP, 8'h07);
    io_write(DP, 8'h33);
    io_read(DP, v);  check("R5 locked data read", v, 8'hFF);
    io_write(IP, 8'h87); io_write(IP, 8'h87);
    io_read(IP, v);  check("R1 index zero after unlock", v, 8'h00);
    check("R5 locked data write ignored", ld_num, 8'h00);
  endtask

  task automatic t_globals;
    logic [7:0] v;
    io_write(IP, 8'h07);
    io_read(IP, v);  check("R6 index readback", v, 8'h07);
    io_write(DP, 8'h06);
    check("R7 ld_num follows select", ld_num, 8'h06);
    io_read(DP, v);  check("R7 select readback", v, 8'h06);
    io_write(IP, 8'h20); io_read(DP, v); check("R8 dev hi", v, 8'h05);
    io_write(IP, 8'h21); io_read(DP, v); check("R8 dev lo", v, 8'h41);
    io_write(IP, 8'h22); io_write(DP, 8'h99); io_read(DP, v);
    check("R8 rev read-only", v, 8'h12);
    io_write(IP, 8'h23); io_read(DP, v); check("R8 ven hi", v, 8'h19);
    io_write(IP, 8'h24); io_read(DP, v); check("R8 ven lo", v, 8'h34);
    io_write(IP, 8'h10); io_write(DP, 8'h77); io_read(DP, v);
    check("R8 unused global reads zero", v, 8'h00);
    check("R8 unused write leaves select", ld_num, 8'h06);
  endtask

  task automatic t_forward;
    logic [7:0] v;
    int w0, r0;
    io_write(IP, 8'h35);
    w0 = wr_pulses;
    io_write(DP, 8'hC3);
    check("R9 ld_wr high after write", ld_wr, 1'b1);
    check("R9 ld_reg", ld_reg, 8'h35);
    check("R9 ld_wdata", ld_wdata, 8'hC3);
    @(negedge clk);
    check("R9 single write pulse", 8'(wr_pulses - w0), 8'd1);
    r0 = rd_pulses;
    io_read(DP, v);
    check("R9 forwarded read data", v, 8'h35 ^ 8'h06 ^ 8'h5A);
    @(negedge clk);
    check("R9 single read pulse", 8'(rd_pulses - r0), 8'd1);
    check("R6 rdata holds", io_rdata, 8'h35 ^ 8'h06 ^ 8'h5A);
  endtask

  task automatic t_foreign;
    logic [7:0] v;
    int w0;
    w0 = wr_pulses;
    io_write(16'h004E, 8'hAA);
    io_write(16'h004F, 8'h11);
    io_read(16'h0010, v);
    check("R10 foreign read holds rdata", v, 8'h35 ^ 8'h06 ^ 8'h5A);
    check("R10 no strobe", 8'(wr_pulses - w0), 8'd0);
    io_read(IP, v);
    check("R10 still open, index kept", v, 8'h35);
  endtask

  task automatic t_lock_and_restart;
    logic [7:0] v;
    int w0;
    io_write(IP, 8'h07);
    io_write(IP, 8'hAA);
    io_read(DP, v);  check("R4 locked after close key", v, 8'hFF);
    w0 = wr_pulses;
    io_write(DP, 8'h44);
    io_write(IP, 8'h87);
    io_read(DP, v);  check("R5 half key still locked", v, 8'hFF);
    io_write(IP, 8'h11);
    io_write(IP, 8'h87);
    io_read(DP, v);  check("R3 sequence restarted", v, 8'hFF);
    io_write(IP, 8'h87);
    io_read(IP, v);  check("R4 index kept across lock", v, 8'h07);
    io_read(DP, v);  check("R5 locked write ignored", v, 8'h06);
    check("R2 reopened select", ld_num, 8'h06);
    check("R5 no strobe while locked", 8'(wr_pulses - w0), 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_globals();
    t_forward();
    t_foreign();
    t_lock_and_restart();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule